// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

A memory-mapped timekeeping block. A 47-bit counter advances once per pulse on a slow tick-enable input, which models a 32.768 kHz clock seen from the bus domain. The upper 32 bits are whole seconds and the lower 15 bits are sub-second ticks. A 32-bit alarm register is compared against the seconds field. On a match with the alarm enabled, a sticky status flag is set. That flag drives a level interrupt and, when a further enable is set, a wakeup output.

Software uses a simple 32-bit register bus with an address, a write strobe, write data and combinational read data. The counter-run and alarm-enable requests are written in the bus domain. They only take effect after a short pipeline that advances on slow ticks. The control register reads back the effective state, so software can poll for the change. There is no read snapshot: a read of the two counter words can straddle a tick, and software must re-read until two reads agree.

Top module: `rtc_lp_top`

## Requirements
- R1: After reset every register reads zero, and `irq_o` and `wake_o` are low.
- R2: Register byte offsets: control 0x04, status 0x18, counter high 0x1C, counter low 0x20, alarm 0x24, scratch 0x30. The scratch and alarm registers are plain 32-bit read/write registers. Any other address reads zero and ignores writes.
- R3: Control bit 0 requests counting, bit 1 requests the alarm and bit 3 enables wakeup. Bits 0 and 1 read back the effective state. That state follows a write on the second tick pulse after it, not before. Bit 3 reads back at once. All other control bits read zero.
- R4: While counting is effective, each tick adds one to the 47-bit counter, and the carry crosses from bit 31 into bit 32. Counter low holds bits 31:0. Counter high holds bits 46:32 in its bits 14:0, and its upper bits read zero and are dropped on write. The counter wraps from all ones to zero.
- R5: Writes to either counter word are ignored while counting is effective.
- R6: Status bit 0 sets one bus clock after the seconds field (counter bits 46:15) equals the alarm value while the alarm is effective. It never sets while the alarm is not effective.
- R7: Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged. A match in the same cycle wins over the clear.
- R8: `irq_o` is status bit 0 AND the effective alarm enable. `wake_o` is `irq_o` AND control bit 3.
- R9: After counting is requested off, the counter keeps counting until the request becomes effective, then holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Slow-clock tick enable, one bus cycle per slow period |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Alarm interrupt level |
| wake_o | output | 1 | Wakeup request level |

## Verification
The bench reads the control register between the first and second tick after a write. A design that applied enables at once, or one tick late, would show the wrong bit. It drives the counter through the bit-31 carry and the 47-bit wrap, where a missing carry or a wrong high-word width leaves a bad high word. It checks that counting continues through the disable delay and then freezes, and that writes to the counter words are dropped while it runs. On the alarm side it checks the one-cycle flag latency and that writing 0 to status leaves the flag set. It checks that a clear loses to a live match, that the interrupt and wakeup gating follow the effective enables, and that a match with the alarm off leaves the flag clear.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int CNT_W  = 47;
  localparam int FRAC_W = 15;
  localparam int SEC_W  = CNT_W - FRAC_W;

  localparam logic [7:0] OFF_CTRL    = 8'h04;
  localparam logic [7:0] OFF_STATUS  = 8'h18;
  localparam logic [7:0] OFF_CNT_HI  = 8'h1C;
  localparam logic [7:0] OFF_CNT_LO  = 8'h20;
  localparam logic [7:0] OFF_ALARM   = 8'h24;
  localparam logic [7:0] OFF_SCRATCH = 8'h30;

  localparam int CTRL_RUN  = 0;
  localparam int CTRL_ALM  = 1;
  localparam int CTRL_WAKE = 3;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] eff_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pipe_q[0] <= '0;
    else if (tick_i)  pipe_q[0] <= req_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pipe_q[s] <= '0;
      else if (tick_i)  pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign eff_o = pipe_q[STAGES-1];

  // R3
  eff_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(eff_o));
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_lp_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         wr_lo_i,
  input  logic         wr_hi_i,
  input  logic [31:0]  wdata_i,
  output logic [W-1:0] cnt_o
);
  localparam int HI_W = W - 32;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (en_i) begin
      if (tick_i) cnt_q <= cnt_q + W'(1);
    end else begin
      if (wr_lo_i) cnt_q[31:0]  <= wdata_i;
      if (wr_hi_i) cnt_q[W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  assign cnt_o = cnt_q;

  // R4
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && en_i) |=> (cnt_o == $past(cnt_o) + W'(1)));

  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
  import rtc_lp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEC_W-1:0] sec_i,
  input  logic             wr_alarm_i,
  input  logic             wr_status_i,
  input  logic [31:0]      wdata_i,
  output logic [SEC_W-1:0] alarm_o,
  output logic             flag_o
);
  logic [SEC_W-1:0] alarm_q;
  logic             flag_q;
  logic             hit;
  logic             clr;

  assign hit = en_i && (sec_i == alarm_q);
  assign clr = wr_status_i && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alarm_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      if (wr_alarm_i) alarm_q <= wdata_i[SEC_W-1:0];
      flag_q <= hit | (flag_q & ~clr);  // match wins over clear
    end
  end

  assign alarm_o = alarm_q;
  assign flag_o  = flag_q;

  // R6
  flag_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(en_i && (sec_i == alarm_o)));

  // R7
  flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_status_i && wdata_i[0] && !en_i) |=> !flag_o);
endmodule

// File: rtl/rtc_lp_top.sv
module rtc_lp_top
  import rtc_lp_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int HI_W = CNT_W - 32;

  logic             run_req_q, alm_req_q, wake_q;
  logic [31:0]      scratch_q;
  logic [1:0]       eff;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] alarm;
  logic             flag;

  logic sel_ctrl, sel_stat, sel_hi, sel_lo, sel_alm, sel_scr;
  assign sel_ctrl = addr_i == ADDR_W'(OFF_CTRL);
  assign sel_stat = addr_i == ADDR_W'(OFF_STATUS);
  assign sel_hi   = addr_i == ADDR_W'(OFF_CNT_HI);
  assign sel_lo   = addr_i == ADDR_W'(OFF_CNT_LO);
  assign sel_alm  = addr_i == ADDR_W'(OFF_ALARM);
  assign sel_scr  = addr_i == ADDR_W'(OFF_SCRATCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_req_q <= 1'b0;
      alm_req_q <= 1'b0;
      wake_q    <= 1'b0;
      scratch_q <= '0;
    end else if (we_i) begin
      if (sel_ctrl) begin
        run_req_q <= wdata_i[CTRL_RUN];
        alm_req_q <= wdata_i[CTRL_ALM];
        wake_q    <= wdata_i[CTRL_WAKE];
      end
      if (sel_scr) scratch_q <= wdata_i;
    end
  end

  rtc_tick_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .tick_i,
    .req_i ({alm_req_q, run_req_q}),
    .eff_o (eff)
  );

  rtc_counter #(.W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .en_i    (eff[0]),
    .wr_lo_i (we_i && sel_lo),
    .wr_hi_i (we_i && sel_hi),
    .wdata_i,
    .cnt_o   (cnt)
  );

  rtc_alarm u_alm (
    .clk_i, .rst_ni,
    .en_i        (eff[1]),
    .sec_i       (cnt[CNT_W-1:FRAC_W]),
    .wr_alarm_i  (we_i && sel_alm),
    .wr_status_i (we_i && sel_stat),
    .wdata_i,
    .alarm_o     (alarm),
    .flag_o      (flag)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[CTRL_RUN]  = eff[0];
      rdata_o[CTRL_ALM]  = eff[1];
      rdata_o[CTRL_WAKE] = wake_q;
    end
    if (sel_stat) rdata_o[0] = flag;
    if (sel_hi)   rdata_o[HI_W-1:0] = cnt[CNT_W-1:32];
    if (sel_lo)   rdata_o = cnt[31:0];
    if (sel_alm)  rdata_o[SEC_W-1:0] = alarm;
    if (sel_scr)  rdata_o = scratch_q;
  end

  assign irq_o  = flag & eff[1];
  assign wake_o = irq_o & wake_q;

  // R8
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> irq_o);

  // R5
  cnt_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eff[0] && !tick_i) |=> $stable(cnt));
endmodule

// File: tb/rtc_lp_top_tb_top.sv
module rtc_lp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_lp_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  typedef struct packed {
    logic [7:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h30, 32'hDEADBEEF, 32'hDEADBEEF},
    '{8'h30, 32'h00000000, 32'h00000000},
    '{8'h24, 32'h89ABCDEF, 32'h89ABCDEF},
    '{8'h20, 32'h12345678, 32'h12345678},
    '{8'h1C, 32'hFFFFFFFF, 32'h00007FFF},
    '{8'h04, 32'hFFFFFFFF, 32'h00000008},
    '{8'h04, 32'h00000000, 32'h00000000},
    '{8'h2C, 32'h00000055, 32'h00000000}
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5ns * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    foreach (VECS[i]) begin
      rd(VECS[i].a, v);
      check("R1 reset value", v, 32'h0);
    end
    rd(8'h18, v); check("R1 status", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 wake", {31'b0, wake}, 32'h0);

    // R2 R3 R4 table walk (no ticks, so enables never take effect)
    foreach (VECS[i]) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, v);
      check("R2 R3 R4 table", v, VECS[i].e);
    end

    // R3 R4 R5 R9
    do_reset();
    wr(8'h20, 32'h7FFF);
    wr(8'h04, 32'h1);
    pulse(); rd(8'h04, v); check("R3 enable after one tick", v, 32'h0);
    pulse(); rd(8'h04, v); check("R3 enable after two ticks", v, 32'h1);
    rd(8'h20, v); check("R4 no count before effective", v, 32'h7FFF);
    pulse(); rd(8'h20, v); check("R4 first count", v, 32'h8000);
    rd(8'h1C, v); check("R4 high word", v, 32'h0);
    wr(8'h20, 32'h1234); rd(8'h20, v); check("R5 lo write ignored", v, 32'h8000);
    wr(8'h1C, 32'h5);    rd(8'h1C, v); check("R5 hi write ignored", v, 32'h0);
    wr(8'h04, 32'h0);
    pulse(); rd(8'h20, v); check("R9 counts during disable delay", v, 32'h8001);
    rd(8'h04, v); check("R3 disable not yet effective", v, 32'h1);
    pulse(); rd(8'h20, v); check("R9 last count", v, 32'h8002);
    rd(8'h04, v); check("R3 disable effective", v, 32'h0);
    pulse(); rd(8'h20, v); check("R9 held", v, 32'h8002);

    // R4 carry into high word
    do_reset();
    wr(8'h20, 32'hFFFFFFFF); wr(8'h1C, 32'h3); wr(8'h04, 32'h1);
    pulse(); pulse(); pulse();
    rd(8'h20, v); check("R4 carry lo", v, 32'h0);
    rd(8'h1C, v); check("R4 carry hi", v, 32'h4);

    // R4 wrap
    do_reset();
    wr(8'h20, 32'hFFFFFFFF); wr(8'h1C, 32'h7FFF); wr(8'h04, 32'h1);
    pulse(); pulse();
    rd(8'h1C, v); check("R4 top value", v, 32'h7FFF);
    pulse();
    rd(8'h20, v); check("R4 wrap lo", v, 32'h0);
    rd(8'h1C, v); check("R4 wrap hi", v, 32'h0);

    // R6 R7 R8 alarm
    do_reset();
    wr(8'h24, 32'd5); wr(8'h20, 32'h27FFC); wr(8'h04, 32'hB);
    pulse(); pulse();
    pulse(); pulse(); pulse();
    idle(1);
    rd(8'h18, v); check("R6 no flag before match", v, 32'h0);
    check("R8 irq low before match", {31'b0, irq}, 32'h0);
    pulse();
    check("R6 flag latency", {31'b0, irq}, 32'h0);
    idle(1);
    rd(8'h18, v); check("R6 flag on match", v, 32'h1);
    check("R8 irq", {31'b0, irq}, 32'h1);
    check("R8 wake", {31'b0, wake}, 32'h1);
    wr(8'h18, 32'h0); rd(8'h18, v); check("R7 write zero keeps flag", v, 32'h1);
    wr(8'h18, 32'h1); rd(8'h18, v); check("R7 match beats clear", v, 32'h1);
    wr(8'h04, 32'h3);
    check("R8 wake gated", {31'b0, wake}, 32'h0);
    check("R8 irq kept", {31'b0, irq}, 32'h1);
    wr(8'h24, 32'd100);
    wr(8'h18, 32'hFFFFFFFF); rd(8'h18, v); check("R7 clear", v, 32'h0);
    check("R8 irq after clear", {31'b0, irq}, 32'h0);
    wr(8'h24, 32'd5); idle(1);
    rd(8'h18, v); check("R6 re-match", v, 32'h1);
    wr(8'h04, 32'h1);
    pulse(); check("R8 irq before alarm-off effective", {31'b0, irq}, 32'h1);
    pulse(); check("R8 irq after alarm-off effective", {31'b0, irq}, 32'h0);
    rd(8'h18, v); check("R8 flag kept while gated", v, 32'h1);
    wr(8'h18, 32'h1); idle(2);
    rd(8'h18, v); check("R6 no set when alarm off", v, 32'h0);

    done = 1'b1;
    finish_run();
  end
endmodule